// File: doc/BRIEF.md
# Signed-Amount Bidirectional Integer Shifter

This block shifts an integer operand left or right by a signed amount. The sign of the amount sets the direction and its magnitude sets the distance. The operand is either the full 64-bit source or only its low 32 bits. In 32-bit mode the upper half of the source passes through to the result unchanged.

The amount has two possible sources:
- A 7-bit two's-complement immediate, gathered from two separate fields of a 32-bit instruction word. In this case a field of the same word also picks the operand width.
- A 32-bit signed value supplied with the operation. In this case a dedicated input picks the width.

Right shifts are arithmetic. A magnitude that reaches or exceeds the operand width saturates.

The result is registered and appears one cycle after a valid request. It holds its value while no request is presented.

Top module: `sgn_shifter_top`

## Requirements
- R1: With `useRegAmt`=0, the amount is the 7-bit two's-complement value whose bits 3..0 come from `instrWord[3:0]` and whose bits 6..4 come from `instrWord[7:5]`. `instrWord[7]` (amount bit 6) is the sign. `instrWord[4]` is ignored.
- R2: An immediate amount of zero or more shifts left by that amount. A negative immediate amount shifts right by its negated value, for example -64 shifts right by 64.
- R3: With `useRegAmt`=0, `instrWord[21:20]`=0 selects a 32-bit shift and `instrWord[21:20]`=2 selects a 64-bit shift. The values 1 and 3 leave the result equal to `srcVal`.
- R4: With `useRegAmt`=1, the signed value on `regAmt` is the amount. A value above zero shifts left. Zero or a negative value shifts right by the negated value, and -2^31 has magnitude 2^31. `wideSel`=1 selects 64-bit mode and `wideSel`=0 selects 32-bit mode.
- R5: Right shifts are arithmetic: vacated positions take the operand's sign bit. That is bit 63 in 64-bit mode and bit 31 in 32-bit mode.
- R6: A magnitude at or beyond the operand width (64 or 32) saturates. A left shift then gives all zeros and a right shift gives all copies of the sign bit.
- R7: In 32-bit mode, `resultOut[63:32]` equals `srcVal[63:32]` of the same request.
- R8: `resultOut` and `outValid` update on the clock edge that samples `inValid`=1. When `inValid`=0, `outValid` falls and `resultOut` holds its value.
- R9: While `rstN` is low, `resultOut` is zero and `outValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| instrWord | input | 32 | Instruction word carrying the immediate amount and the width field |
| srcVal | input | 64 | Source operand |
| regAmt | input | 32 | Signed register-supplied amount |
| useRegAmt | input | 1 | 1 selects `regAmt` as the amount, 0 selects the immediate |
| wideSel | input | 1 | Width for register amounts: 1 selects 64 bits, 0 selects 32 bits |
| outValid | output | 1 | Result valid, one cycle after `inValid` |
| resultOut | output | 64 | Shift result |

## Verification
The hardest cases to reach from the ports are the magnitude extremes. These are a register amount of exactly -2^31, whose negation only fits with an extra bit, and an immediate of -64, whose negation overflows 7 bits. Amounts landing exactly on or one below the operand width are equally hard, because there the saturation path and the barrel path must agree.

Directed requests hit each of these edges. The random phase then biases half of its amounts into a small window around 31, 32, 63 and 64 of either sign, so the width-boundary comparison is exercised repeatedly in both modes.

// File: rtl/sgn_shift_pkg.sv
package sgn_shift_pkg;
  localparam int DATA_W      = 64;
  localparam int HALF_W      = DATA_W / 2;
  localparam int REG_AMT_W   = 32;
  localparam int MAG_W       = REG_AMT_W + 1;
  localparam int IMM_W       = 7;
  localparam int INSTR_W     = 32;
  localparam logic [1:0] OP_SH32 = 2'd0;
  localparam logic [1:0] OP_SH64 = 2'd2;

  typedef struct packed {
    logic             load;
    logic             wide;
    logic             goLeft;
    logic             passThru;
    logic [MAG_W-1:0] mag;
  } shiftCtrl_t;
endpackage

// File: rtl/sgn_shift_ctrl.sv
module sgn_shift_ctrl
  import sgn_shift_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [INSTR_W-1:0]   instrWord,
  input  logic [REG_AMT_W-1:0] regAmt,
  input  logic                 useRegAmt,
  input  logic                 wideSel,
  output shiftCtrl_t           ctrl
);
  logic signed [IMM_W-1:0] immAmt;
  logic                    immNeg;
  logic [IMM_W-1:0]        immMag;
  logic [1:0]              opField;
  logic                    regPos;
  logic [MAG_W-1:0]        regExt;
  logic [MAG_W-1:0]        regMag;
  logic                    unusedInstr;

  assign unusedInstr = ^{instrWord[31:22], instrWord[19:8], instrWord[4]};

  // split immediate: low nibble from bits 3..0, top three bits from 7..5
  assign immAmt  = {instrWord[7:5], instrWord[3:0]};
  assign immNeg  = immAmt[IMM_W-1];
  assign immMag  = immNeg ? (~immAmt + 1'b1) : immAmt;
  assign opField = instrWord[21:20];

  assign regPos  = !regAmt[REG_AMT_W-1] && (regAmt != '0);
  assign regExt  = {regAmt[REG_AMT_W-1], regAmt};
  assign regMag  = regPos ? regExt : (~regExt + 1'b1);

  always_comb begin
    ctrl.load = inValid;
    if (useRegAmt) begin
      ctrl.wide     = wideSel;
      ctrl.goLeft   = regPos;
      ctrl.passThru = 1'b0;
      ctrl.mag      = regMag;
    end else begin
      ctrl.wide     = (opField == OP_SH64);
      ctrl.goLeft   = !immNeg;
      ctrl.passThru = (opField != OP_SH32) && (opField != OP_SH64);
      ctrl.mag      = {{(MAG_W-IMM_W){1'b0}}, immMag};
    end
  end

  AST_IMM_SIGN_DIR: assert property (@(posedge clk) disable iff (!rstN)
    (!useRegAmt) |-> (ctrl.goLeft == !instrWord[7])); // R1
  AST_REG_ZERO_RIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (useRegAmt && regAmt == '0) |-> (!ctrl.goLeft && ctrl.mag == '0)); // R4
  AST_REG_MIN_MAG: assert property (@(posedge clk) disable iff (!rstN)
    (useRegAmt && regAmt == {1'b1, {(REG_AMT_W-1){1'b0}}}) |-> (ctrl.mag[MAG_W-1:MAG_W-2] == 2'b01)); // R4
endmodule

// File: rtl/sgn_shift_dpath.sv
module sgn_shift_dpath
  import sgn_shift_pkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  shiftCtrl_t       ctrl,
  input  logic [WIDTH-1:0] srcVal,
  output logic             outValid,
  output logic [WIDTH-1:0] resultOut
);
  localparam int HALF   = WIDTH / 2;
  localparam int STAGES = $clog2(WIDTH);

  logic [WIDTH-1:0] operand;
  logic [WIDTH-1:0] leftStage  [STAGES+1];
  logic [WIDTH-1:0] rightStage [STAGES+1];
  logic [MAG_W-1:0] widthLimit;
  logic             saturate;
  logic [WIDTH-1:0] satVal;
  logic [WIDTH-1:0] coreVal;
  logic [WIDTH-1:0] nextVal;

  assign operand    = ctrl.wide ? srcVal : {{HALF{srcVal[HALF-1]}}, srcVal[HALF-1:0]};
  assign widthLimit = ctrl.wide ? MAG_W'(WIDTH) : MAG_W'(HALF);
  assign saturate   = (ctrl.mag >= widthLimit);
  assign satVal     = ctrl.goLeft ? '0 : {WIDTH{operand[WIDTH-1]}};

  assign leftStage[0]  = operand;
  assign rightStage[0] = operand;
  for (genvar s = 0; s < STAGES; s++) begin : g_barrel
    localparam int DIST = 1 << s;
    assign leftStage[s+1]  = ctrl.mag[s]
      ? {leftStage[s][WIDTH-DIST-1:0], {DIST{1'b0}}} : leftStage[s];
    assign rightStage[s+1] = ctrl.mag[s]
      ? {{DIST{rightStage[s][WIDTH-1]}}, rightStage[s][WIDTH-1:DIST]} : rightStage[s];
  end

  assign coreVal = saturate ? satVal
                 : (ctrl.goLeft ? leftStage[STAGES] : rightStage[STAGES]);
  assign nextVal = ctrl.passThru ? srcVal
                 : (ctrl.wide ? coreVal : {srcVal[WIDTH-1:HALF], coreVal[HALF-1:0]});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      resultOut <= '0;
    end else begin
      outValid <= ctrl.load;
      if (ctrl.load) resultOut <= nextVal;
    end
  end

  AST_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && !ctrl.wide) |=> (resultOut[WIDTH-1:HALF] == $past(srcVal[WIDTH-1:HALF]))); // R7
  AST_ZERO_AMT_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.mag == '0) |=> (resultOut == $past(srcVal))); // R2
  AST_SAT_LEFT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.wide && ctrl.goLeft && !ctrl.passThru && ctrl.mag >= MAG_W'(WIDTH))
      |=> (resultOut == '0)); // R6
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> outValid); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> (!outValid && $stable(resultOut))); // R8
endmodule

// File: rtl/sgn_shifter_top.sv
module sgn_shifter_top
  import sgn_shift_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] instrWord,
  input  logic [63:0] srcVal,
  input  logic [31:0] regAmt,
  input  logic        useRegAmt,
  input  logic        wideSel,
  output logic        outValid,
  output logic [63:0] resultOut
);
  shiftCtrl_t ctrl;

  sgn_shift_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .instrWord (instrWord),
    .regAmt    (regAmt),
    .useRegAmt (useRegAmt),
    .wideSel   (wideSel),
    .ctrl      (ctrl)
  );

  sgn_shift_dpath #(.WIDTH(DATA_W)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .srcVal    (srcVal),
    .outValid  (outValid),
    .resultOut (resultOut)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (!outValid && resultOut == '0)); // R9
endmodule

// File: tb/sgn_shifter_tb.sv
module sgn_shifter_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [31:0] instrWord;
  logic [63:0] srcVal;
  logic [31:0] regAmt;
  logic        useRegAmt;
  logic        wideSel;
  logic        outValid;
  logic [63:0] resultOut;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sgn_shifter_top dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .srcVal(srcVal), .regAmt(regAmt), .useRegAmt(useRegAmt), .wideSel(wideSel),
    .outValid(outValid), .resultOut(resultOut)
  );

  function automatic logic [63:0] model(input logic [31:0] ins, input logic [63:0] src,
                                        input logic [31:0] ra, input logic useReg,
                                        input logic wsel);
    longint amt, mag, w;
    logic wide, pass, left;
    logic signed [6:0] i7;
    logic [63:0] op, r;
    if (useReg) begin
      amt = longint'($signed(ra));
      wide = wsel; pass = 1'b0; left = (amt > 0);
    end else begin
      i7 = {ins[7:5], ins[3:0]};
      amt = longint'(i7);
      wide = (ins[21:20] == 2'd2);
      pass = ins[20];
      left = (amt >= 0);
    end
    mag = left ? amt : -amt;
    w = wide ? 64 : 32;
    op = wide ? src : {{32{src[31]}}, src[31:0]};
    if (left) r = (mag >= w) ? 64'd0 : (op << mag);
    else      r = (mag >= w) ? {64{op[63]}} : 64'($signed(op) >>> mag);
    if (pass) return src;
    return wide ? r : {src[63:32], r[31:0]};
  endfunction

  function automatic logic [31:0] mkInstr(input logic [1:0] op, input logic [6:0] amt,
                                          input logic [31:0] noise);
    logic [31:0] v;
    v = noise;
    v[3:0] = amt[3:0];
    v[7:5] = amt[6:4];
    v[21:20] = op;
    return v;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run(input string req, input logic [31:0] ins, input logic [63:0] src,
                     input logic [31:0] ra, input logic ur, input logic ws);
    logic [63:0] exp;
    exp = model(ins, src, ra, ur, ws);
    instrWord = ins; srcVal = src; regAmt = ra; useRegAmt = ur; wideSel = ws;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(req, resultOut, exp);
    check({req, " valid R8"}, {63'd0, outValid}, 64'd1);
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd2024));
    rstN = 1'b0; inValid = 1'b0; instrWord = '0; srcVal = '1; regAmt = '0;
    useRegAmt = 1'b0; wideSel = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset result", resultOut, 64'd0);
    check("R9 reset valid", {63'd0, outValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2: +5 in 64-bit, bit 4 set as noise
    run("R1 R2 imm left", mkInstr(2'd2, 7'd5, 32'h0000_0010), 64'h0123_4567_89AB_CDEF, '0, 0, 0);
    check("R2 imm left value", resultOut, 64'h2468_ACF1_3579_BDE0);
    // R5: -5 on a negative operand
    run("R5 imm arith right", mkInstr(2'd2, 7'h7B, 0), 64'h8000_0000_0000_0100, '0, 0, 0);
    check("R5 right value", resultOut, 64'hFC00_0000_0000_0008);
    run("R6 imm -64 saturates", mkInstr(2'd2, 7'h40, 0), 64'h8000_0000_0000_0000, '0, 0, 0);
    run("R2 imm +63", mkInstr(2'd2, 7'd63, 0), 64'h3, '0, 0, 0);
    run("R6 R7 imm32 +40", mkInstr(2'd0, 7'd40, 0), 64'hDEAD_BEEF_FFFF_FFFF, '0, 0, 0);
    check("R7 upper kept", resultOut, 64'hDEAD_BEEF_0000_0000);
    run("R5 R7 imm32 -1", mkInstr(2'd0, 7'h7F, 0), 64'h1111_2222_8000_0000, '0, 0, 0);
    check("R5 imm32 value", resultOut, 64'h1111_2222_C000_0000);
    run("R3 op1 passes", mkInstr(2'd1, 7'd9, 0), 64'hCAFE_F00D_1234_5678, '0, 0, 0);
    run("R3 op3 passes", mkInstr(2'd3, 7'h70, 0), 64'h0BAD_0BAD_0BAD_0BAD, '0, 0, 0);
    run("R4 reg zero", 32'hFFFF_FFFF, 64'h8765_4321_0FED_CBA9, 32'd0, 1, 1);
    run("R4 R6 reg min", 32'd0, 64'h8000_0000_0000_0001, 32'h8000_0000, 1, 1);
    run("R4 R6 reg 100 left", 32'd0, 64'hFFFF_FFFF_FFFF_FFFF, 32'd100, 1, 1);
    run("R4 R7 reg32 7", 32'd0, 64'hAAAA_5555_0000_0003, 32'd7, 1, 0);
    check("R4 reg32 value", resultOut, 64'hAAAA_5555_0000_0180);
    run("R6 reg32 -32", 32'd0, 64'h0000_0000_7FFF_FFFF, 32'hFFFF_FFE0, 1, 0);

    // R8 hold while idle
    held = resultOut;
    srcVal = 64'h1; instrWord = mkInstr(2'd2, 7'd1, 0);
    @(negedge clk);
    check("R8 hold result", resultOut, held);
    check("R8 valid low", {63'd0, outValid}, 64'd0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, noise;
      logic [6:0]  amt;
      logic [63:0] src;
      logic ur;
      src = {$urandom(), $urandom()};
      noise = $urandom();
      ur = $urandom_range(1, 0) == 1;
      if ($urandom_range(1, 0) == 1) begin
        int b;
        b = ($urandom_range(1, 0) == 1) ? 32 : 64;
        b = b + $urandom_range(2, 0) - 1;
        if ($urandom_range(1, 0) == 1) b = -b;
        ra = 32'(b);
        amt = 7'(b);
      end else begin
        ra = $urandom();
        amt = 7'($urandom());
      end
      run("R1 R2 R3 R4 R5 R6 R7 random", mkInstr(2'($urandom()), amt, noise), src, ra, ur,
          1'($urandom()));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule